// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a supervisory timer that software must service inside a timing window instead of at any moment. Once armed, it first runs a closed window, in which servicing is forbidden, and then an open window, in which software must restart it. Each window length is a separate clock-cycle count that software programs. Servicing too early, or not servicing at all before the open window runs out, raises a sticky reset request for the chip's reset controller.

Software reaches the block through a plain 32-bit register port that takes single-cycle writes and gives combinational reads. The control register is write-guarded. A one-shot unlock bit must be written in a separate register just before each control write. The unlock then clears itself, so a stray write cannot disarm the timer or service it. The interrupt output mirrors a flag that records an expired open window. Software clears that flag by writing 1 to it.

Top module: `window_watchdog`

## Requirements
- R1: After reset every register reads 0, and `rst_req_o` and `irq_o` are 0.
- R2: A write to the control register (byte offset 0x04) is ignored unless bit 0 of the unlock register (offset 0x00) is 1. Writing 1 to bit 0 of 0x00 sets the unlock bit, which reads back at 0x00 bit 0.
- R3: The unlock bit returns to 0 after any single write to 0x04, so a second control write with no new unlock is ignored.
- R4: Offset 0x0C holds the closed-window length and offset 0x10 holds the open-window length, each a 32-bit cycle count that reads back as written. Writes to these offsets need no unlock, and a length of 0 behaves as 1. Offset 0x08 reads 0.
- R5: Control bit 0 is the enable. A control write that takes it from 0 to 1 starts the closed window, which lasts the closed length in cycles. The open window follows and lasts the open length.
- R6: If the open window runs out with no kick, `rst_req_o` goes to 1 on that edge. The timeout flag (control bit 16) and `irq_o` are set on the same edge.
- R7: Writing 1 to control bit 8 (the kick) during the open window restarts the closed window. Bit 8 always reads 0.
- R8: A kick during the closed window, up to and including its last cycle, sets `rst_req_o` and leaves the timeout flag at 0.
- R9: A kick in the last cycle of the open window restarts the sequence, and no timeout occurs.
- R10: Writing 1 to control bit 16 clears the timeout flag. If the flag is set and cleared on the same edge, the set wins. `rst_req_o` stays at 1 until reset.
- R11: While the enable is 0, the timer is stopped, kicks are ignored and no reset request can arise. Enabling again starts a fresh closed window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, taken with bus_sel on a rising edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req_o | output | 1 | Sticky reset request |
| irq_o | output | 1 | Timeout flag, level |

## Verification
Two pairs of events can land on the same edge: a kick and the expiry of the open window, and a flag-clearing write and the flag being set by that same expiry. The bench counts edges from the arming write and issues the control write exactly on the final open-window edge. A kick there must restart the timer, which is judged by the absence of a reset request for a further full period and its arrival at the expected later edge. A clear there must leave the flag set, with `irq_o` and `rst_req_o` both at 1.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int OFF_UNLOCK = 'h00;
  localparam int OFF_CTRL   = 'h04;
  localparam int OFF_FUNC   = 'h08;
  localparam int OFF_CLOSED = 'h0C;
  localparam int OFF_OPEN   = 'h10;

  localparam int BIT_EN   = 0;
  localparam int BIT_KICK = 8;
  localparam int BIT_FLAG = 16;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_CLOSED,
    ST_OPEN,
    ST_TRIPPED
  } wwd_state_e;
endpackage

// File: rtl/wwd_regs.sv
module wwd_regs
  import wwd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              expire_i,
  output logic              unlock_o,
  output logic              enable_o,
  output logic              flag_o,
  output logic [CNT_W-1:0]  closed_len_o,
  output logic [CNT_W-1:0]  open_len_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              kick_o
);
  logic wr_unlock, wr_ctrl, wr_closed, wr_open, ctrl_ok;
  logic unlock_q, enable_q, flag_q;
  logic [CNT_W-1:0] closed_q, open_q;

  assign wr_unlock = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_UNLOCK));
  assign wr_ctrl   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_closed = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CLOSED));
  assign wr_open   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_OPEN));
  assign ctrl_ok   = wr_ctrl && unlock_q;

  // Sequencer commands decoded from a guarded control write
  assign start_o = ctrl_ok &&  bus_wdata[BIT_EN] && !enable_q;
  assign stop_o  = ctrl_ok && !bus_wdata[BIT_EN];
  assign kick_o  = ctrl_ok &&  bus_wdata[BIT_EN] && bus_wdata[BIT_KICK] && enable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      enable_q <= 1'b0;
      flag_q   <= 1'b0;
      closed_q <= '0;
      open_q   <= '0;
    end else begin
      if (wr_ctrl)
        unlock_q <= 1'b0;
      else if (wr_unlock && bus_wdata[0])
        unlock_q <= 1'b1;
      if (ctrl_ok)
        enable_q <= bus_wdata[BIT_EN];
      // set has priority over a same-edge clear
      if (expire_i)
        flag_q <= 1'b1;
      else if (ctrl_ok && bus_wdata[BIT_FLAG])
        flag_q <= 1'b0;
      if (wr_closed) closed_q <= bus_wdata[CNT_W-1:0];
      if (wr_open)   open_q   <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFF_UNLOCK): bus_rdata[0] = unlock_q;
      ADDR_W'(OFF_CTRL): begin
        bus_rdata[BIT_EN]   = enable_q;
        bus_rdata[BIT_FLAG] = flag_q;
      end
      ADDR_W'(OFF_CLOSED): bus_rdata = DATA_W'(closed_q);
      ADDR_W'(OFF_OPEN):   bus_rdata = DATA_W'(open_q);
      default:             bus_rdata = '0;
    endcase
  end

  assign unlock_o     = unlock_q;
  assign enable_o     = enable_q;
  assign flag_o       = flag_q;
  assign closed_len_o = closed_q;
  assign open_len_o   = open_q;
endmodule

// File: rtl/wwd_seq.sv
module wwd_seq
  import wwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] closed_len_i,
  input  logic [CNT_W-1:0] open_len_i,
  output logic             expire_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  wwd_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;
  logic             last;

  assign last     = (cnt_q <= ONE);
  assign expire_o = (state_q == ST_OPEN) && last && !kick_i && !stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      req_q   <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_OFF;
    end else if (start_i) begin
      state_q <= ST_CLOSED;
      cnt_q   <= closed_len_i;
    end else begin
      unique case (state_q)
        ST_CLOSED: begin
          if (kick_i) begin
            req_q   <= 1'b1;
            state_q <= ST_TRIPPED;
          end else if (last) begin
            state_q <= ST_OPEN;
            cnt_q   <= open_len_i;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        ST_OPEN: begin
          if (kick_i) begin
            state_q <= ST_CLOSED;
            cnt_q   <= closed_len_i;
          end else if (last) begin
            req_q   <= 1'b1;
            state_q <= ST_TRIPPED;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign rst_req_o = req_q;
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wwd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req_o,
  output logic              irq_o
);
  logic unlock, enable, flag, start, stop, kick, expire;
  logic [CNT_W-1:0] closed_len, open_len;

  wwd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .expire_i(expire), .unlock_o(unlock), .enable_o(enable), .flag_o(flag),
    .closed_len_o(closed_len), .open_len_o(open_len),
    .start_o(start), .stop_o(stop), .kick_o(kick)
  );

  wwd_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .kick_i(kick),
    .closed_len_i(closed_len), .open_len_i(open_len),
    .expire_o(expire), .rst_req_o(rst_req_o)
  );

  assign irq_o = flag;
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rst_req_o,
  input logic              irq_o,
  input logic              unlock,
  input logic              enable
);
  logic ctrl_wr;
  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(4));

  a_r2_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !unlock) |=> $stable(enable));

  a_r3_unlock_once: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !unlock);

  a_r6_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> rst_req_o);

  a_r7_kick_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(4)) |-> !bus_rdata[8]);

  a_r10_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> rst_req_o);

  a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !$rose(rst_req_o));
endmodule

bind window_watchdog wwd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .rst_req_o(rst_req_o),
  .irq_o(irq_o), .unlock(unlock), .enable(enable)
);

// File: tb/window_watchdog_test.sv
`timescale 1ns/1ps
module window_watchdog_test;
  localparam int NC = 5;  // closed length
  localparam int NO = 4;  // open length

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req_o, irq_o;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  window_watchdog uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic ctrl_write(input logic [31:0] d);
    bus_write(5'h00, 32'h1);
    bus_write(5'h04, d);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    bus_sel = 1'b0; bus_wr = 1'b0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic program_lengths();
    bus_write(5'h0C, NC);
    bus_write(5'h10, NO);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    for (int a = 0; a <= 16; a += 4) begin
      rd(5'(a), v);
      chk("R1 register reset", v, 32'h0);
    end
    chk("R1 rst_req_o", {31'b0, rst_req_o}, 32'h0);
    chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_lock_and_lengths();
    logic [31:0] v;
    do_reset();
    program_lengths();
    rd(5'h0C, v); chk("R4 closed length", v, NC);
    rd(5'h10, v); chk("R4 open length", v, NO);
    rd(5'h08, v); chk("R4 offset 0x08", v, 32'h0);
    bus_write(5'h04, 32'h1);
    rd(5'h04, v); chk("R2 locked write ignored", v, 32'h0);
    idle(NC + NO + 2);
    chk("R2 no start when locked", {31'b0, rst_req_o}, 32'h0);
    bus_write(5'h00, 32'h1);
    rd(5'h00, v); chk("R2 unlock readback", v, 32'h1);
    bus_write(5'h04, 32'h0);
    rd(5'h00, v); chk("R3 unlock self-clears", v, 32'h0);
    bus_write(5'h04, 32'h1);
    rd(5'h04, v); chk("R3 second write ignored", v, 32'h0);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    do_reset();
    program_lengths();
    ctrl_write(32'h1);
    rd(5'h04, v); chk("R5 enable set", v, 32'h1);
    idle(NC + NO - 1);
    chk("R5 no request before open end", {31'b0, rst_req_o}, 32'h0);
    idle(1);
    chk("R6 request on expiry", {31'b0, rst_req_o}, 32'h1);
    chk("R6 irq on expiry", {31'b0, irq_o}, 32'h1);
    rd(5'h04, v); chk("R6 flag bit 16", v, 32'h10001);
    ctrl_write(32'h10000);
    chk("R10 flag cleared", {31'b0, irq_o}, 32'h0);
    chk("R10 request sticky", {31'b0, rst_req_o}, 32'h1);
  endtask

  task automatic t_open_kick();
    logic [31:0] v;
    do_reset();
    program_lengths();
    ctrl_write(32'h1);
    idle(NC - 1);
    ctrl_write(32'h101);  // first open-window edge
    rd(5'h04, v); chk("R7 kick reads 0", v, 32'h1);
    idle(NC + NO - 1);
    chk("R7 restarted, no request yet", {31'b0, rst_req_o}, 32'h0);
    idle(1);
    chk("R7 expiry after restart", {31'b0, rst_req_o}, 32'h1);
  endtask

  task automatic t_closed_kick();
    do_reset();
    program_lengths();
    ctrl_write(32'h1);
    idle(NC - 2);
    ctrl_write(32'h101);  // last closed-window edge
    chk("R8 violation request", {31'b0, rst_req_o}, 32'h1);
    chk("R8 no flag", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_last_cycle_kick();
    do_reset();
    program_lengths();
    ctrl_write(32'h1);
    idle(NC + NO - 2);
    ctrl_write(32'h101);  // final open-window edge
    chk("R9 kick beats expiry", {31'b0, rst_req_o}, 32'h0);
    chk("R9 no flag", {31'b0, irq_o}, 32'h0);
    idle(NC + NO - 1);
    chk("R9 restarted window", {31'b0, rst_req_o}, 32'h0);
    idle(1);
    chk("R9 later expiry", {31'b0, rst_req_o}, 32'h1);
  endtask

  task automatic t_clear_collision();
    do_reset();
    program_lengths();
    ctrl_write(32'h1);
    idle(NC + NO - 2);
    ctrl_write(32'h10001);  // clear lands on the expiry edge
    chk("R10 set wins over clear", {31'b0, irq_o}, 32'h1);
    chk("R10 request on collision", {31'b0, rst_req_o}, 32'h1);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    do_reset();
    program_lengths();
    ctrl_write(32'h1);
    idle(2);
    ctrl_write(32'h0);
    idle(40);
    chk("R11 held while off", {31'b0, rst_req_o}, 32'h0);
    ctrl_write(32'h100);
    rd(5'h04, v); chk("R11 kick while off ignored", v, 32'h0);
    idle(NC + NO);
    chk("R11 no request while off", {31'b0, rst_req_o}, 32'h0);
    ctrl_write(32'h1);
    idle(NC + NO - 1);
    chk("R11 fresh window", {31'b0, rst_req_o}, 32'h0);
    idle(1);
    chk("R11 expiry after re-enable", {31'b0, rst_req_o}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_lock_and_lengths();
    t_timeout();
    t_open_kick();
    t_closed_kick();
    t_last_cycle_kick();
    t_clear_collision();
    t_disabled();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule